// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block derives an output clock from one of several input clocks by dividing the selected clock by an integer. A plain combinational select picks the input clock. All sequential logic runs on that selected clock. The output starts and stops only on whole periods. It can also be forced inactive at once, without waiting for any edge.

Several controls shape the waveform. Duty correction gives a 50% output for odd divisors. A two-bit start delay holds the start back by up to three input cycles. A nudge input moves the output phase later by one input cycle for each rising edge it sees. A status output reports when the generator is actually producing periods.

Software or a control wrapper drives the control inputs as static levels. The output feeds a pad or a downstream clock consumer.

Top module: `clk_out_gen`

## Requirements
- R1: The input clock is `clk_src[src_sel]`. For a select value with no matching source, the input clock is constant 0.
- R2: For an effective divisor N of 2 or more, with correction off, every output period is N input cycles long. The output is high for the first ceil(N/2) cycles of each period and low for the rest.
- R3: A divisor value of 0 acts as 1. With an effective divisor of 1, `clk_out` follows the input clock while running: high in the first half of each input cycle and low in the second half.
- R4: With `dc50_en` high and an odd effective divisor N of 3 or more, each period is high for exactly N half input cycles. A change to `dc50_en` while running takes effect only from the start of a following period. It has no effect for even divisors.
- R5: When idle, an input-clock edge that samples `enable` high after it was low arms the start. `running` and `clk_out` go high phase+1 input edges after that edge. `phase` is sampled only at the arming edge, so changing it while running has no effect.
- R6: After `enable` is sampled low, the generator stops at the end of the current complete period. Every pulse it issued has full length. `running` falls on that boundary, and `clk_out` then stays low.
- R7: A high `kill` forces `clk_out` and `running` low at once, with no clock edge needed.
- R8: After `kill` or `rst`, a level-high `enable` does not start the generator. A fresh low-to-high transition of `enable` is required.
- R9: Each rising edge of `nudge` seen while running stretches exactly one period by one input cycle, added to the low phase. The high time stays the same.
- R10: A rising edge of `nudge` while the generator is stopped is discarded and does not stretch any later period.
- R11: A new `divisor` value applies from the start of the next period. No period mixes the old and new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | N_SRC | Candidate input clocks |
| src_sel | input | SEL_W | Index of the input clock to use |
| rst | input | 1 | Synchronous active-high reset, in the selected clock domain |
| kill | input | 1 | Asynchronous immediate stop |
| enable | input | 1 | Clean start/stop request |
| dc50_en | input | 1 | Duty correction for odd divisors |
| phase | input | 2 | Start delay in input cycles, sampled at arming |
| nudge | input | 1 | A rising edge delays the output phase by one input cycle |
| divisor | input | 8 | Integer divide ratio (0 acts as 1) |
| clk_out | output | 1 | Generated clock |
| running | output | 1 | High while the generator is producing periods |

## Verification
Checks on every input-clock edge in the RTL cover four things:
- a start only follows a sampled-high enable;
- a clean stop only follows a sampled-low enable;
- the period counter stays inside the current divisor;
- the registered output stays low while idle, and a period is held only when a nudge stretch was pending.

The directed bench scenarios are needed for what shows only in the waveform. This covers:
- period and high-time lengths for even and odd divisors, with and without correction;
- input-clock passthrough;
- start delays of 0 and 3;
- the single stretched period after a nudge;
- the immediate kill between clock edges;
- the need for a fresh enable edge after kill;
- source selection, measured as an output period in nanoseconds.

// File: rtl/cgo_pkg.sv
`timescale 1ns/1ps
package cgo_pkg;

    localparam int DIV_W   = 8;
    localparam int PHASE_W = 2;

    typedef logic [DIV_W-1:0]   div_t;
    typedef logic [PHASE_W-1:0] phase_t;

    // Configuration latched at each period start
    typedef struct packed {
        div_t div;
        logic dc;
    } pcfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;

    // A zero divisor behaves as one
    function automatic div_t eff_div(div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    // Half-cycle correction applies to odd ratios of three or more
    function automatic logic odd_fix(pcfg_t c);
        return c.dc && c.div[0] && (eff_div(c.div) >= div_t'(3));
    endfunction

    // Number of whole input cycles the registered output is high
    function automatic div_t high_cycles(pcfg_t c);
        div_t n;
        n = eff_div(c.div);
        if (odd_fix(c))
            return n >> 1;
        return (n >> 1) + div_t'(n[0]);
    endfunction

endpackage

// File: rtl/cgo_nudge_sync.sv
`timescale 1ns/1ps
module cgo_nudge_sync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk_in,
    input  logic rst,
    input  logic nudge,
    output logic nudge_edge
);
    localparam int LAST = SYNC_LEN;

    logic [LAST:0] shift_q;

    always_ff @(posedge clk_in) begin
        if (rst)
            shift_q <= '0;
        else
            shift_q <= {shift_q[LAST-1:0], nudge};
    end

    // One-cycle pulse on a synchronised rising edge
    assign nudge_edge = shift_q[LAST-1] & ~shift_q[LAST];

endmodule

// File: rtl/cgo_start_ctl.sv
`timescale 1ns/1ps
module cgo_start_ctl
    import cgo_pkg::*;
(
    input  logic   clk_in,
    input  logic   rst,
    input  logic   kill,
    input  logic   enable,
    input  phase_t phase,
    input  logic   period_last,
    output logic   run,
    output logic   go,
    output logic   stop
);
    gen_state_t st_q, st_n;
    phase_t     dly_q, dly_n;
    logic       en_prev_q;
    logic       clr_seen_q;

    always_comb begin
        st_n  = st_q;
        dly_n = dly_q;
        go    = 1'b0;
        stop  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (enable && !en_prev_q) begin
                    st_n  = ST_WAIT;
                    dly_n = phase;
                end
            end
            ST_WAIT: begin
                if (!enable) begin
                    st_n = ST_IDLE;
                end else if (dly_q == '0) begin
                    st_n = ST_RUN;
                    go   = 1'b1;
                end else begin
                    dly_n = dly_q - phase_t'(1);
                end
            end
            ST_RUN: begin
                if (!enable && period_last) begin
                    st_n = ST_IDLE;
                    stop = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // en_prev is forced high on clear so that a held enable needs a new edge
    always_ff @(posedge clk_in or posedge kill) begin
        if (kill) begin
            st_q      <= ST_IDLE;
            dly_q     <= '0;
            en_prev_q <= 1'b1;
        end else if (rst) begin
            st_q      <= ST_IDLE;
            dly_q     <= '0;
            en_prev_q <= 1'b1;
        end else begin
            st_q      <= st_n;
            dly_q     <= dly_n;
            en_prev_q <= enable;
        end
    end

    assign run = (st_q == ST_RUN);

    // Marks the first edge after any clear, used to gate edge checks
    always_ff @(posedge clk_in or posedge kill) begin
        if (kill)
            clr_seen_q <= 1'b1;
        else
            clr_seen_q <= rst;
    end

    // R5: running only begins after enable was sampled high
    a_r5_start_on_enable: assert property (@(posedge clk_in) disable iff (rst || kill)
        $rose(run) |-> $past(enable));

    // R6: a clean stop only follows a sampled-low enable
    a_r6_stop_on_low: assert property (@(posedge clk_in) disable iff (rst || kill || clr_seen_q)
        $fell(run) |-> !$past(enable));

endmodule

// File: rtl/cgo_divider.sv
`timescale 1ns/1ps
module cgo_divider
    import cgo_pkg::*;
(
    input  logic  clk_in,
    input  logic  rst,
    input  logic  kill,
    input  logic  run,
    input  logic  go,
    input  logic  stop,
    input  logic  nudge_edge,
    input  pcfg_t cfg_in,
    output logic  out_q,
    output pcfg_t cfg_cur,
    output logic  period_last
);
    div_t cnt_q;
    div_t last;
    div_t cnt_inc;
    logic pend_q;

    assign last        = eff_div(cfg_cur.div) - div_t'(1);
    assign cnt_inc     = cnt_q + div_t'(1);
    assign period_last = run && (cnt_q == last) && !pend_q;

    always_ff @(posedge clk_in or posedge kill) begin
        if (kill) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            out_q   <= 1'b0;
            cfg_cur <= '0;
        end else if (rst) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            out_q   <= 1'b0;
            cfg_cur <= '0;
        end else if (go) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            out_q   <= 1'b1;
            cfg_cur <= cfg_in;
        end else if (!run || stop) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            out_q   <= 1'b0;
        end else if (cnt_q == last) begin
            if (pend_q) begin
                // Hold the final low cycle once more
                pend_q <= nudge_edge;
            end else begin
                cnt_q   <= '0;
                out_q   <= 1'b1;
                cfg_cur <= cfg_in;
                pend_q  <= nudge_edge;
            end
        end else begin
            cnt_q <= cnt_inc;
            out_q <= (cnt_inc < high_cycles(cfg_cur));
            if (nudge_edge)
                pend_q <= 1'b1;
        end
    end

    // R2: the counter never leaves the current period
    a_r2_cnt_in_range: assert property (@(posedge clk_in) disable iff (rst || kill)
        run |-> (cnt_q <= last));

    // R6: the registered output is low whenever idle
    a_r6_low_when_idle: assert property (@(posedge clk_in) disable iff (rst || kill)
        !run |-> !out_q);

    // R9: a period is held only at its end and only for a pending nudge
    a_r9_hold_needs_nudge: assert property (@(posedge clk_in) disable iff (rst || kill)
        (run && $past(run) && $past(last) != '0 && last != '0 && cnt_q == $past(cnt_q))
            |-> ($past(pend_q) && cnt_q == last));

endmodule

// File: rtl/cgo_out_stage.sv
`timescale 1ns/1ps
module cgo_out_stage
    import cgo_pkg::*;
#(
    parameter bit DUTY_FIX_EN = 1'b1
) (
    input  logic  clk_in,
    input  logic  rst,
    input  logic  kill,
    input  logic  run,
    input  logic  out_q,
    input  pcfg_t cfg_cur,
    output logic  clk_out
);
    logic run_neg_q;
    logic pass;
    logic div_path;

    // Gate for passthrough is updated while the input clock is low
    always_ff @(negedge clk_in or posedge kill) begin
        if (kill)
            run_neg_q <= 1'b0;
        else if (rst)
            run_neg_q <= 1'b0;
        else
            run_neg_q <= run;
    end

    assign pass = (eff_div(cfg_cur.div) == div_t'(1));

    generate
        if (DUTY_FIX_EN) begin : g_fix
            logic out_neg_q;
            always_ff @(negedge clk_in or posedge kill) begin
                if (kill)
                    out_neg_q <= 1'b0;
                else if (rst)
                    out_neg_q <= 1'b0;
                else
                    out_neg_q <= out_q;
            end
            assign div_path = out_q | (odd_fix(cfg_cur) & out_neg_q);
        end else begin : g_nofix
            assign div_path = out_q;
        end
    endgenerate

    assign clk_out = pass ? (run_neg_q & clk_in) : div_path;

endmodule

// File: rtl/clk_out_gen.sv
`timescale 1ns/1ps
module clk_out_gen
    import cgo_pkg::*;
#(
    parameter int N_SRC       = 4,
    parameter int SEL_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    parameter int NUDGE_SYNC  = 2,
    parameter bit DUTY_FIX_EN = 1'b1
) (
    input  logic [N_SRC-1:0]   clk_src,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               rst,
    input  logic               kill,
    input  logic               enable,
    input  logic               dc50_en,
    input  logic [PHASE_W-1:0] phase,
    input  logic               nudge,
    input  logic [DIV_W-1:0]   divisor,
    output logic               clk_out,
    output logic               running
);
    logic  clk_in;
    logic  nudge_edge;
    logic  run, go, stop, period_last;
    logic  out_q;
    pcfg_t cfg_in, cfg_cur;

    // Plain source select; switching while running may glitch
    always_comb begin
        clk_in = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (src_sel == SEL_W'(i))
                clk_in = clk_src[i];
    end

    assign cfg_in = '{div: divisor, dc: dc50_en};

    cgo_nudge_sync #(.SYNC_LEN(NUDGE_SYNC)) u_sync (
        .clk_in     (clk_in),
        .rst        (rst),
        .nudge      (nudge),
        .nudge_edge (nudge_edge)
    );

    cgo_start_ctl u_ctl (
        .clk_in      (clk_in),
        .rst         (rst),
        .kill        (kill),
        .enable      (enable),
        .phase       (phase),
        .period_last (period_last),
        .run         (run),
        .go          (go),
        .stop        (stop)
    );

    cgo_divider u_div (
        .clk_in      (clk_in),
        .rst         (rst),
        .kill        (kill),
        .run         (run),
        .go          (go),
        .stop        (stop),
        .nudge_edge  (nudge_edge),
        .cfg_in      (cfg_in),
        .out_q       (out_q),
        .cfg_cur     (cfg_cur),
        .period_last (period_last)
    );

    cgo_out_stage #(.DUTY_FIX_EN(DUTY_FIX_EN)) u_out (
        .clk_in  (clk_in),
        .rst     (rst),
        .kill    (kill),
        .run     (run),
        .out_q   (out_q),
        .cfg_cur (cfg_cur),
        .clk_out (clk_out)
    );

    assign running = run;

endmodule

// File: tb/test_clk_out_gen.sv
`timescale 1ns/1ps
module test_clk_out_gen;

    logic       clk0 = 1'b0;
    logic       clk1 = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       rst = 1'b1;
    logic       kill = 1'b0;
    logic       enable = 1'b0;
    logic       dc50_en = 1'b0;
    logic [1:0] phase = 2'd0;
    logic       nudge = 1'b0;
    logic [7:0] divisor = 8'd4;
    logic       clk_out;
    logic       running;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit cap [0:599];
    int ncap;
    int per_q[$];
    int hi_q[$];
    int last_hi;
    int tail_ones;

    always #2.5 clk0 = ~clk0;
    always #6.5 clk1 = ~clk1;

    clk_out_gen i_clk_out_gen (
        .clk_src (4'({1'b0, 1'b0, clk1, clk0})),
        .src_sel (src_sel),
        .rst     (rst),
        .kill    (kill),
        .enable  (enable),
        .dc50_en (dc50_en),
        .phase   (phase),
        .nudge   (nudge),
        .divisor (divisor),
        .clk_out (clk_out),
        .running (running)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Two samples per input cycle, away from both clock edges
    task automatic capture(int cycles);
        ncap = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk0); #1.25;
            cap[ncap] = clk_out; ncap++;
            @(negedge clk0); #1.25;
            cap[ncap] = clk_out; ncap++;
        end
    endtask

    // Complete periods (rise to rise) and their high lengths, in half cycles
    task automatic analyze();
        int r;
        int hl;
        per_q.delete();
        hi_q.delete();
        r = -1;
        hl = -1;
        for (int i = 1; i < ncap; i++) begin
            if (cap[i] && !cap[i-1]) begin
                if (r >= 0) begin
                    per_q.push_back(i - r);
                    hi_q.push_back(hl);
                end
                r = i;
                hl = -1;
            end else if (!cap[i] && cap[i-1] && r >= 0 && hl < 0) begin
                hl = i - r;
            end
        end
        last_hi = hl;
        tail_ones = 0;
        if (r >= 0 && hl >= 0)
            for (int i = r + hl; i < ncap; i++)
                if (cap[i]) tail_ones++;
    endtask

    task automatic start_gen(string req, int n, bit dc, int ph);
        @(negedge clk0);
        divisor = 8'(n);
        dc50_en = dc;
        phase = 2'(ph);
        enable = 1'b1;
        for (int k = 1; k <= ph + 2; k++) begin
            @(posedge clk0); #1;
            if (k < ph + 2) begin
                chk({req, " running before delay"}, int'(running), 0);
            end else begin
                chk({req, " running after delay"}, int'(running), 1);
                if (n >= 2) chk({req, " clk_out at start"}, int'(clk_out), 1);
            end
        end
    endtask

    task automatic stop_gen();
        @(negedge clk0);
        enable = 1'b0;
        repeat (40) @(posedge clk0);
        #1;
        chk("R6 stopped after enable low", int'(running), 0);
        chk("R6 output held low", int'(clk_out), 0);
    endtask

    task automatic t_reset();
        enable = 1'b1;
        repeat (4) @(posedge clk0);
        #1;
        chk("R7 reset clk_out", int'(clk_out), 0);
        chk("R7 reset running", int'(running), 0);
        @(negedge clk0);
        rst = 1'b0;
        repeat (10) @(posedge clk0);
        #1;
        chk("R8 held enable after reset", int'(running), 0);
        @(negedge clk0);
        enable = 1'b0;
        repeat (2) @(posedge clk0);
    endtask

    task automatic t_latency();
        start_gen("R5 phase0", 4, 1'b0, 0);
        stop_gen();
        start_gen("R5 phase3", 4, 1'b0, 3);
        @(negedge clk0);
        phase = 2'd0;
        capture(24);
        analyze();
        chk("R5 phase change ignored: running", int'(running), 1);
        foreach (per_q[i]) chk("R5 period after phase change", per_q[i], 8);
        stop_gen();
    endtask

    task automatic t_divide(int n, bit dc, string req);
        int exp_hi;
        start_gen(req, n, dc, 0);
        capture(4 * n + 4);
        analyze();
        exp_hi = (dc && (n % 2 == 1) && n >= 3) ? n : 2 * ((n + 1) / 2);
        chk({req, " period count"}, int'(per_q.size() >= 2), 1);
        foreach (per_q[i]) begin
            chk({req, " period"}, per_q[i], 2 * n);
            chk({req, " high"}, hi_q[i], exp_hi);
        end
        stop_gen();
    endtask

    task automatic t_dc_live();
        int nq;
        start_gen("R4 live", 5, 1'b0, 0);
        @(negedge clk0);
        dc50_en = 1'b1;
        repeat (12) @(posedge clk0);
        capture(25);
        analyze();
        nq = per_q.size();
        chk("R4 live periods seen", int'(nq >= 2), 1);
        foreach (hi_q[i]) chk("R4 live high after toggle", hi_q[i], 5);
        foreach (per_q[i]) chk("R4 live period", per_q[i], 10);
        stop_gen();
        dc50_en = 1'b0;
    endtask

    task automatic t_pass(int dv);
        int miss;
        start_gen("R3 passthrough", dv, 1'b0, 0);
        repeat (3) @(posedge clk0);
        capture(12);
        miss = 0;
        for (int i = 0; i < ncap; i++)
            if (cap[i] != ((i % 2) == 0)) miss++;
        chk("R3 passthrough mismatches", miss, 0);
        stop_gen();
    endtask

    task automatic t_div_change();
        int n8;
        int n12;
        int other;
        start_gen("R11 change", 4, 1'b0, 0);
        repeat (5) @(posedge clk0);
        fork
            capture(50);
            begin
                repeat (9) @(negedge clk0);
                divisor = 8'd6;
            end
        join
        analyze();
        n8 = 0; n12 = 0; other = 0;
        foreach (per_q[i]) begin
            if (per_q[i] == 8) n8++;
            else if (per_q[i] == 12) n12++;
            else other++;
        end
        chk("R11 no mixed period", other, 0);
        chk("R11 new divisor used", int'(n12 >= 2), 1);
        chk("R11 final period", per_q[per_q.size()-1], 12);
        stop_gen();
    endtask

    task automatic t_nudge();
        int n10;
        int other;
        start_gen("R9 nudge", 4, 1'b0, 0);
        fork
            capture(48);
            begin
                repeat (13) @(negedge clk0);
                nudge = 1'b1;
                repeat (3) @(negedge clk0);
                nudge = 1'b0;
            end
        join
        analyze();
        n10 = 0; other = 0;
        foreach (per_q[i]) begin
            if (per_q[i] == 10) n10++;
            else if (per_q[i] != 8) other++;
            chk("R9 high unchanged", hi_q[i], 4);
        end
        chk("R9 one stretched period", n10, 1);
        chk("R9 other periods", other, 0);
        stop_gen();
    endtask

    task automatic t_nudge_idle();
        @(negedge clk0);
        nudge = 1'b1;
        repeat (3) @(negedge clk0);
        nudge = 1'b0;
        repeat (6) @(negedge clk0);
        fork
            capture(30);
            start_gen("R10 start", 4, 1'b0, 0);
        join
        analyze();
        chk("R10 periods seen", int'(per_q.size() >= 2), 1);
        foreach (per_q[i]) chk("R10 no stretch from idle nudge", per_q[i], 8);
        stop_gen();
    endtask

    task automatic t_clean_stop();
        start_gen("R6 stop", 5, 1'b0, 0);
        fork
            capture(60);
            begin
                repeat (23) @(negedge clk0);
                enable = 1'b0;
            end
        join
        analyze();
        foreach (hi_q[i]) chk("R6 full pulse", hi_q[i], 6);
        chk("R6 last pulse full", last_hi, 6);
        chk("R6 low after stop", tail_ones, 0);
        chk("R6 running fell", int'(running), 0);
    endtask

    task automatic t_kill();
        int guard;
        start_gen("R7 kill", 6, 1'b0, 0);
        repeat (4) @(posedge clk0);
        guard = 0;
        do begin
            @(posedge clk0); #1;
            guard++;
        end while (!clk_out && guard < 20);
        #0.5 kill = 1'b1;
        #0.5;
        chk("R7 clk_out killed before edge", int'(clk_out), 0);
        chk("R7 running killed before edge", int'(running), 0);
        repeat (3) @(posedge clk0);
        @(negedge clk0);
        kill = 1'b0;
        repeat (10) @(posedge clk0);
        #1;
        chk("R8 held enable after kill", int'(running), 0);
        chk("R8 output low after kill", int'(clk_out), 0);
        @(negedge clk0);
        enable = 1'b0;
        @(negedge clk0);
        enable = 1'b1;
        repeat (2) @(posedge clk0);
        #1;
        chk("R8 fresh edge restarts", int'(running), 1);
        stop_gen();
    endtask

    task automatic t_source();
        realtime t1;
        realtime t2;
        @(negedge clk0);
        src_sel = 2'd1;
        divisor = 8'd2;
        #20;
        enable = 1'b1;
        #120;
        @(posedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        chk("R1 period from source 1 (ps)", int'((t2 - t1) * 1000.0), 26000);
        enable = 1'b0;
        #200;
        chk("R1 source 1 stopped", int'(running), 0);
        @(negedge clk0);
        src_sel = 2'd0;
        repeat (3) @(posedge clk0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_divide(2, 1'b0, "R2 div2");
        t_divide(3, 1'b0, "R2 div3");
        t_divide(4, 1'b0, "R2 div4");
        t_divide(7, 1'b0, "R2 div7");
        t_divide(5, 1'b1, "R4 div5 corrected");
        t_divide(3, 1'b1, "R4 div3 corrected");
        t_divide(4, 1'b1, "R4 div4 even");
        t_dc_live();
        t_pass(1);
        t_pass(0);
        t_div_change();
        t_nudge();
        t_nudge_idle();
        t_clean_stop();
        t_kill();
        t_source();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule